// File: doc/BRIEF.md
# Ramp Counter Sample Capture Controller

This block owns the shared digital ramp counter of a parallel-ramp pulse-position converter and turns crossing events into packed samples. An external comparator network raises an asynchronous detect line when the input signal meets the ramp. The block brings that line into the clock domain and accepts its rising edge. It then stores the present count, the count direction and the partition code reported by the comparator encoder in a sample register. On the following clock it restarts the counter.

Because the counter restarts at every accepted crossing, the spacing between samples follows the signal. The counter alternates between counting up and counting down after each restart. A hold-off window keeps the counter free of new captures until it has settled. Rising edges that arrive inside that window are discarded and tallied in a saturating drop counter.

Top module: `ramp_sample_capture`

## Requirements
- R1: While reset is held and right after it, the count is 0, the direction is up (slope_up_o = 1), load_o and sample_valid_o are 0 and drop_count_o is 0.
- R2: Outside a restart, the counter moves by one per clock: up by 1 and holding at 2^CNT_W-1 when counting up, down by 1 and holding at 0 when counting down.
- R3: detect_async passes through two synchronizer flops. At the second rising clock edge that samples it high, load_o goes high for exactly one cycle, and only once for each high level.
- R4: At the clock edge that ends a load_o cycle, sample_word_o takes {slope, partition, count}: bit CNT_W+PART_W is the slope (1 = up), bits CNT_W+PART_W-1 down to CNT_W are the partition, and bits CNT_W-1 down to 0 are the count shown during the load_o cycle. sample_valid_o is high for that one following cycle.
- R5: One clock after the capture edge, the direction inverts. The counter restarts at 0 if the new direction is up, or at 2^CNT_W-1 if it is down.
- R6: A rising edge is not accepted from the load_o cycle through the cycle that follows the counter restart. Two load_o pulses are therefore at least 3 clocks apart.
- R7: A rising edge inside the hold-off window raises no load_o and no sample, and it does not restart the counter. It increments drop_count_o, which holds at 2^DROP_W-1.
- R8: The partition field carries the value of part_code during the load_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| detect_async | input | 1 | Crossing detect from the comparator edge detector, asynchronous |
| part_code | input | PART_W | Partition number of the crossing |
| count_o | output | CNT_W | Present ramp counter value |
| slope_up_o | output | 1 | Present count direction, 1 = up |
| load_o | output | 1 | One-cycle strobe for an accepted crossing |
| sample_valid_o | output | 1 | One-cycle strobe qualifying sample_word_o |
| sample_word_o | output | 1+PART_W+CNT_W | Packed sample {slope, partition, count} |
| drop_count_o | output | DROP_W | Saturating count of crossings discarded during hold-off |

## Verification
The bench places a second crossing two clocks after the first, where it must be dropped, and three clocks after, where it must be accepted. A hold-off that is one cycle too short would take an extra sample, and one that is one cycle too long would lose a valid one. It runs the ramp into both end values to catch a counter that wraps instead of holding. It also captures in both directions, so that a restart to the wrong end value, or a slope bit taken after the toggle instead of before it, shows up in the stored word. A burst of dropped crossings drives the drop counter past its top value, which catches a counter that wraps there.

// File: rtl/ramp_cap_pkg.sv
package ramp_cap_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} ramp_dir_e;
endpackage

// File: rtl/rcap_sync.sv
module rcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcap_ramp_ctr.sv
module rcap_ramp_ctr
  import ramp_cap_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c, input logic up);
    if (up) return (c == TOP) ? TOP : c + 1'b1;
    else    return (c == '0)  ? '0  : c - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] start_value(input logic up);
    return up ? '0 : TOP;
  endfunction

  ramp_dir_e        dir_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_UP;
      cnt_q <= '0;
    end else if (restart_i) begin
      dir_q <= (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;
      cnt_q <= start_value(dir_q != DIR_UP);
    end else begin
      cnt_q <= step_count(cnt_q, dir_q == DIR_UP);
    end
  end

  assign count_o  = cnt_q;
  assign dir_up_o = (dir_q == DIR_UP);

  // R5: direction flips and the counter sits at the start of the new ramp
  assert_dir_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (dir_up_o != $past(dir_up_o)));
  assert_restart_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> ((dir_up_o && count_o == '0) || (!dir_up_o && count_o == TOP)));
  // R2: hold at the end value
  assert_hold_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && dir_up_o && count_o == TOP) |=> (count_o == TOP));
  assert_hold_bottom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !dir_up_o && count_o == '0) |=> (count_o == '0));
endmodule

// File: rtl/rcap_capture.sv
module rcap_capture #(
  parameter int CNT_W  = 8,
  parameter int PART_W = 3,
  parameter int DROP_W = 8,
  parameter int SETTLE = 1,
  localparam int WORD_W = 1 + PART_W + CNT_W,
  localparam int SET_W  = $clog2(SETTLE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_sync_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              dir_up_i,
  input  logic [PART_W-1:0] part_i,
  output logic              load_o,
  output logic              restart_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam logic [DROP_W-1:0] DROP_TOP = '1;

  function automatic logic [WORD_W-1:0] pack_sample(input logic up,
      input logic [PART_W-1:0] p, input logic [CNT_W-1:0] c);
    return {up, p, c};
  endfunction

  logic             det_q;
  logic             rst_pend_q;
  logic [SET_W-1:0] settle_q;
  logic             rise_w, hold_w, drop_w;

  assign rise_w    = det_sync_i & ~det_q;
  assign hold_w    = rst_pend_q | (settle_q != '0);
  assign load_o    = rise_w & ~hold_w;
  assign drop_w    = rise_w & hold_w;
  assign restart_o = rst_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q      <= 1'b0;
      rst_pend_q <= 1'b0;
      settle_q   <= '0;
      valid_o    <= 1'b0;
      word_o     <= '0;
      drop_cnt_o <= '0;
    end else begin
      det_q      <= det_sync_i;
      rst_pend_q <= load_o;
      valid_o    <= load_o;
      if (load_o) word_o <= pack_sample(dir_up_i, part_i, count_i);
      if (rst_pend_q)           settle_q <= SET_W'(SETTLE);
      else if (settle_q != '0)  settle_q <= settle_q - 1'b1;
      if (drop_w && drop_cnt_o != DROP_TOP) drop_cnt_o <= drop_cnt_o + 1'b1;
    end
  end

  // R6: accepted crossings at least three clocks apart
  assert_load_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (!$past(load_o) && !$past(load_o, 2)));
  // R4: each accepted crossing yields exactly one valid sample
  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> valid_o);
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R7: a drop below the top value adds exactly one
  assert_drop_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_w && drop_cnt_o != DROP_TOP) |=> (drop_cnt_o == $past(drop_cnt_o) + 1'b1));
  assert_drop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt_o == DROP_TOP) |=> (drop_cnt_o == DROP_TOP));
endmodule

// File: rtl/ramp_sample_capture.sv
module ramp_sample_capture #(
  parameter int CNT_W   = 8,
  parameter int PART_W  = 3,
  parameter int DROP_W  = 8,
  parameter int SETTLE  = 1,
  parameter int SYNC_ST = 2,
  localparam int WORD_W = 1 + PART_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              detect_async,
  input  logic [PART_W-1:0] part_code,
  output logic [CNT_W-1:0]  count_o,
  output logic              slope_up_o,
  output logic              load_o,
  output logic              sample_valid_o,
  output logic [WORD_W-1:0] sample_word_o,
  output logic [DROP_W-1:0] drop_count_o
);
  logic det_sync_w;
  logic restart_w;

  rcap_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(detect_async), .q_o(det_sync_w)
  );

  rcap_ramp_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_w),
    .count_o(count_o), .dir_up_o(slope_up_o)
  );

  rcap_capture #(.CNT_W(CNT_W), .PART_W(PART_W), .DROP_W(DROP_W), .SETTLE(SETTLE)) u_cap (
    .clk(clk), .rst_n(rst_n), .det_sync_i(det_sync_w),
    .count_i(count_o), .dir_up_i(slope_up_o), .part_i(part_code),
    .load_o(load_o), .restart_o(restart_w), .valid_o(sample_valid_o),
    .word_o(sample_word_o), .drop_cnt_o(drop_count_o)
  );

  // R5: restart comes one clock after the accepted crossing
  assert_restart_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> restart_w);
  // R4: stored slope matches the direction in force at the load cycle
  assert_slope_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (sample_word_o[WORD_W-1] == $past(slope_up_o)));
endmodule

// File: tb/ramp_sample_capture_tb_top.sv
module ramp_sample_capture_tb_top;
  localparam int CW = 8, PW = 3, DW = 4;
  logic clk = 1'b0, rst_n = 1'b0, detect = 1'b0;
  logic [PW-1:0] part = '0;
  logic [CW-1:0] count;
  logic slope, load, valid;
  logic [11:0] word;
  logic [DW-1:0] drops;
  int checks = 0, fails = 0, valids = 0;

  always #10 clk = ~clk;

  ramp_sample_capture #(.CNT_W(CW), .PART_W(PW), .DROP_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .detect_async(detect), .part_code(part),
    .count_o(count), .slope_up_o(slope), .load_o(load), .sample_valid_o(valid),
    .sample_word_o(word), .drop_count_o(drops)
  );

  // reference model built from the requirements
  bit m_s1, m_s2, m_s3, m_rst, m_up, m_valid;
  int m_settle, m_cnt, m_drop;
  logic [11:0] m_word;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rst = 0; m_up = 1; m_valid = 0;
      m_settle = 0; m_cnt = 0; m_drop = 0; m_word = '0;
    end else begin
      bit rise, hold, acc;
      rise = m_s2 && !m_s3;
      hold = m_rst || (m_settle != 0);
      acc  = rise && !hold;
      m_valid = acc;
      if (acc) m_word = {m_up, part, 8'(m_cnt)};
      if (rise && hold && m_drop < 15) m_drop++;
      if (m_rst) m_settle = 1; else if (m_settle > 0) m_settle--;
      if (m_rst) begin m_up = !m_up; m_cnt = m_up ? 0 : 255; end
      else if (m_up) begin if (m_cnt < 255) m_cnt++; end
      else begin if (m_cnt > 0) m_cnt--; end
      m_rst = acc;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = detect;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2 count", count, m_cnt);
    check("R5 slope", slope, m_up);
    check("R3 load", load, m_s2 && !m_s3 && !(m_rst || m_settle != 0));
    check("R4 valid", valid, m_valid);
    if (valid) begin valids++; check("R4 word", word, m_word); end
    check("R7 drops", drops, m_drop);
  end

  task automatic pulse(input int width);
    @(negedge clk); detect = 1'b1;
    repeat (width) @(negedge clk);
    detect = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; repeat (3) @(negedge clk);
    check("R1 count", count, 0); check("R1 slope", slope, 1);
    check("R1 valid", valid, 0); check("R1 load", load, 0); check("R1 drops", drops, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ramp_up;
    @(negedge clk); repeat (20) @(negedge clk);
    check("R2 up ramp", count, 21);
  endtask

  task automatic t_capture(input int p, input int exp_slope, input int delta);
    int c0, v0;
    part = PW'(p); v0 = valids;
    @(negedge clk); c0 = count; detect = 1'b1;
    @(negedge clk); detect = 1'b0;
    @(negedge clk);
    check("R3 load seen", load, 1);
    @(negedge clk);
    check("R4 valid", valid, 1);
    check("R4 slope bit", word[11], exp_slope);
    check("R8 partition", word[10:8], p);
    check("R4 count field", word[7:0], c0 + delta);
    @(negedge clk);
    check("R5 new slope", slope, 1 - exp_slope);
    check("R5 restart", count, exp_slope ? 255 : 0);
    repeat (4) @(negedge clk);
    check("R4 one sample", valids - v0, 1);
  endtask

  task automatic t_saturate(input int exp);
    repeat (300) @(negedge clk);
    check("R2 saturate", count, exp);
  endtask

  task automatic t_close(input int gap, input int exp_samples, input int exp_drop);
    int v0, d0;
    v0 = valids; d0 = drops;
    @(negedge clk); detect = 1'b1;
    @(negedge clk); detect = 1'b0;
    repeat (gap - 1) @(negedge clk);
    detect = 1'b1;
    @(negedge clk); detect = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 samples", valids - v0, exp_samples);
    check("R7 drop step", drops - d0, exp_drop);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_ramp_up();
    t_capture(5, 1, 2);      // R4 R8 from up ramp
    t_capture(2, 0, -2);     // R4 R5 from down ramp
    t_saturate(255);         // R2 up end
    t_capture(7, 1, 0);
    t_saturate(0);           // R2 down end
    t_close(2, 1, 1);        // R6 R7 second edge in hold-off
    t_close(3, 2, 0);        // R6 spacing of three accepted
    for (int i = 0; i < 20; i++) t_close(2, 1, (drops < 15) ? 1 : 0);
    check("R7 sticky top", drops, 15);
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule